// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder with Refresh Row Counter

This block watches the control strobes of an asynchronous extended-data-out DRAM (row strobe, four per-lane column strobes, write enable, output enable) with a fast oversampling clock. It stands in for the control front end of the memory, so a memory controller can be checked against it. Every interval in which the row strobe is low is sorted into one cycle kind. The kind is decided only by the order in which the strobe edges arrive. When the row strobe rises again, the block reports that kind together with the row that was used.

The block also holds the internal refresh row counter that the refresh cycles driven by column strobes step through. It raises a flag when such a refresh has been held long enough to become self-refresh. Per data lane, it decides whether the data pins would be driven, following the extended-data-out hold rules and the high-impedance rules. A bench compares the reported kinds and rows with the command sequence it meant to issue. It compares the lane drive outputs with the bus behaviour it expects.

Top module: `dram_strobe_decoder`

## Requirements
- R1: A row strobe fall while at least one column strobe is already low, with no held read in progress, starts a column-first refresh. The row reported is the refresh counter value, the counter then advances by one, kind code 5 is reported, and no lane drives during the cycle.
- R2: A row strobe low interval in which every column strobe stays high reports kind code 4 with the address sampled at the row strobe fall, and leaves the refresh counter unchanged.
- R3: If a read ends with a column strobe still low and the row strobe then falls again, the cycle is a hidden refresh. It reports kind code 6 with the counter row, the counter advances, and lanes that were driving keep driving while the row strobe is low.
- R4: If write enable is low when the first column strobe falls, the cycle reports kind code 2 (early write) and no lane drives.
- R5: If write enable is high at the first column strobe fall and never falls later, the cycle reports kind code 1 (read). With output enable low, exactly the lanes whose column strobe fell drive.
- R6: If write enable falls after a column strobe has fallen with write enable high, the cycle reports kind code 3 (read-modify-write). The lanes drive before the fall and stop after it.
- R7: A driving lane keeps driving after its column strobe rises while the row strobe is still low. It stops once both the row strobe and its column strobe are high.
- R8: Output enable high or write enable low turns every lane off, one clock after the strobe is sampled.
- R9: A column-first refresh whose row strobe stays low for more than SELF_CYC clocks raises the self-refresh flag and reports kind code 7. A shorter one leaves the flag low and reports code 5. The flag clears when the row strobe rises.
- R10: The report strobe is high for exactly one clock per row strobe rise and never in two consecutive clocks.
- R11: The refresh counter is 12 bits wide when REFRESH_ROWS is 4096 and 11 bits wide when it is 2048, and it wraps from all ones to zero.
- R12: After reset, no lane drives, the report strobe and the self-refresh flag are low, and the refresh counter is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | LANES | Per-lane column strobes, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ROW_W | Multiplexed address, sampled as the row at the row strobe fall |
| cyc_valid | output | 1 | One-clock report strobe after a row strobe rise |
| cyc_type | output | 3 | Kind code of the finished cycle |
| cyc_row | output | ROW_W | Row used by the finished cycle |
| refresh_row | output | ROW_W | Current internal refresh counter |
| self_refresh | output | 1 | High while a column-first refresh has turned into self-refresh |
| dq_oe | output | LANES | Per-lane data drive decision |

## Verification
The bench drives each edge ordering of the strobes: row strobe alone, column strobe before row strobe (short and long), read, early write, read-modify-write, and a read followed by a hidden refresh. Each kind code is told apart from its nearest neighbour by a single reordered edge. One example is write enable falling before versus after the column strobe. Another is the column strobe being held from a read versus lowered fresh before the row strobe. Lane drive is checked on a partial lane mask, against output enable and write enable overrides, and across the column strobe rise that the extended-data hold must survive. A long run of refresh cycles takes the counter through its wrap.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

   typedef enum logic [2:0] {
      CYC_NONE     = 3'd0,
      CYC_READ     = 3'd1,
      CYC_EWRITE   = 3'd2,
      CYC_RMW      = 3'd3,
      CYC_RASONLY  = 3'd4,
      CYC_CASFIRST = 3'd5,
      CYC_HIDDEN   = 3'd6,
      CYC_SELFREF  = 3'd7
   } cyc_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ACCESS,
      ST_CASFIRST,
      ST_HIDDEN
   } fsm_state_e;

endpackage

// File: rtl/dsd_strobe_sampler.sv
module dsd_strobe_sampler #(
   parameter int LANES = 4,
   parameter int ROW_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ras_n,
   input  logic [LANES-1:0] cas_n,
   input  logic             we_n,
   input  logic             oe_n,
   input  logic [ROW_W-1:0] addr,
   output logic             s_ras_n,
   output logic             ras_fall,
   output logic             ras_rise,
   output logic [LANES-1:0] s_cas_n,
   output logic [LANES-1:0] cas_fall,
   output logic             s_we_n,
   output logic             we_fall,
   output logic             s_oe_n,
   output logic [ROW_W-1:0] s_addr
);

   logic             p_ras_n;
   logic [LANES-1:0] p_cas_n;
   logic             p_we_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_ras_n <= 1'b1;
         p_ras_n <= 1'b1;
         s_cas_n <= '1;
         p_cas_n <= '1;
         s_we_n  <= 1'b1;
         p_we_n  <= 1'b1;
         s_oe_n  <= 1'b1;
         s_addr  <= '0;
      end else begin
         s_ras_n <= ras_n;
         p_ras_n <= s_ras_n;
         s_cas_n <= cas_n;
         p_cas_n <= s_cas_n;
         s_we_n  <= we_n;
         p_we_n  <= s_we_n;
         s_oe_n  <= oe_n;
         s_addr  <= addr;
      end
   end

   assign ras_fall = p_ras_n & ~s_ras_n;
   assign ras_rise = ~p_ras_n & s_ras_n;
   assign we_fall  = p_we_n & ~s_we_n;

   for (genvar i = 0; i < LANES; i++) begin : g_cas_edge
      assign cas_fall[i] = p_cas_n[i] & ~s_cas_n[i];
   end

   p_edges_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ras_rise |=> !ras_rise);

endmodule

// File: rtl/dsd_row_counter.sv
module dsd_row_counter #(
   parameter int ROW_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [ROW_W-1:0] count
);

   always_ff @(posedge clk) begin
      if (!rst_n)   count <= '0;
      else if (inc) count <= count + 1'b1;
   end

   p_hold_without_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(count));

endmodule

// File: rtl/dsd_cycle_fsm.sv
module dsd_cycle_fsm
   import dsd_pkg::*;
#(
   parameter int LANES    = 4,
   parameter int ROW_W    = 12,
   parameter int SELF_CYC = 25000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ras_fall,
   input  logic             ras_rise,
   input  logic [LANES-1:0] s_cas_n,
   input  logic [LANES-1:0] cas_fall,
   input  logic             s_we_n,
   input  logic             we_fall,
   input  logic [ROW_W-1:0] s_addr,
   input  logic [ROW_W-1:0] ref_row,
   output logic             ref_inc,
   output logic             casfirst_go,
   output logic             in_access,
   output logic             in_casfirst,
   output logic             cyc_valid,
   output cyc_kind_e        cyc_type,
   output logic [ROW_W-1:0] cyc_row,
   output logic             self_refresh
);

   localparam int SC_W = $clog2(SELF_CYC + 1);
   localparam logic [SC_W-1:0] SC_LIMIT = SC_W'(SELF_CYC);

   fsm_state_e       state;
   logic             cas_seen;
   logic             early_wr;
   logic             rmw_seen;
   logic             read_held;
   logic [SC_W-1:0]  sc_cnt;
   cyc_kind_e        kind_now;
   logic             any_cas_low;

   assign any_cas_low = ~&s_cas_n;
   assign ref_inc     = (state == ST_IDLE) && ras_fall && any_cas_low;
   assign casfirst_go = ref_inc && !read_held;
   assign in_access   = (state == ST_ACCESS);
   assign in_casfirst = (state == ST_CASFIRST);

   always_comb begin
      kind_now = CYC_NONE;
      case (state)
         ST_ACCESS: begin
            if (!cas_seen)     kind_now = CYC_RASONLY;
            else if (early_wr) kind_now = CYC_EWRITE;
            else if (rmw_seen) kind_now = CYC_RMW;
            else               kind_now = CYC_READ;
         end
         ST_CASFIRST: kind_now = self_refresh ? CYC_SELFREF : CYC_CASFIRST;
         ST_HIDDEN:   kind_now = CYC_HIDDEN;
         default:     kind_now = CYC_NONE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         cas_seen     <= 1'b0;
         early_wr     <= 1'b0;
         rmw_seen     <= 1'b0;
         read_held    <= 1'b0;
         sc_cnt       <= '0;
         self_refresh <= 1'b0;
         cyc_valid    <= 1'b0;
         cyc_type     <= CYC_NONE;
         cyc_row      <= '0;
      end else begin
         cyc_valid <= 1'b0;
         if (state != ST_IDLE && ras_rise) begin
            cyc_valid    <= 1'b1;
            cyc_type     <= kind_now;
            state        <= ST_IDLE;
            self_refresh <= 1'b0;
            read_held    <= any_cas_low &&
                            (kind_now == CYC_READ || kind_now == CYC_HIDDEN);
         end else begin
            case (state)
               ST_IDLE: begin
                  if (!any_cas_low) read_held <= 1'b0;
                  if (ras_fall) begin
                     sc_cnt   <= '0;
                     cas_seen <= 1'b0;
                     early_wr <= 1'b0;
                     rmw_seen <= 1'b0;
                     if (any_cas_low) begin
                        state   <= read_held ? ST_HIDDEN : ST_CASFIRST;
                        cyc_row <= ref_row;
                     end else begin
                        state   <= ST_ACCESS;
                        cyc_row <= s_addr;
                     end
                  end
               end
               ST_ACCESS: begin
                  if (|cas_fall && !cas_seen) begin
                     cas_seen <= 1'b1;
                     early_wr <= ~s_we_n;
                  end else if (cas_seen && !early_wr && we_fall) begin
                     rmw_seen <= 1'b1;
                  end
               end
               ST_CASFIRST: begin
                  if (sc_cnt == SC_LIMIT) self_refresh <= 1'b1;
                  else                    sc_cnt <= sc_cnt + 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   p_valid_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_valid |=> !cyc_valid);

   p_selfref_in_refresh_r9: assert property (@(posedge clk) disable iff (!rst_n)
      self_refresh |-> in_casfirst);

endmodule

// File: rtl/dsd_lane_drive.sv
module dsd_lane_drive #(
   parameter int LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             s_ras_n,
   input  logic [LANES-1:0] s_cas_n,
   input  logic [LANES-1:0] cas_fall,
   input  logic             s_we_n,
   input  logic             s_oe_n,
   input  logic             in_access,
   input  logic             casfirst_go,
   output logic [LANES-1:0] dq_oe
);

   logic [LANES-1:0] lane_act;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n)
            lane_act[i] <= 1'b0;
         else if (casfirst_go || (s_ras_n && s_cas_n[i]))
            lane_act[i] <= 1'b0;
         else if (cas_fall[i] && !s_ras_n && in_access && s_we_n)
            lane_act[i] <= 1'b1;
      end
      assign dq_oe[i] = lane_act[i] & ~s_oe_n & s_we_n;
   end

   p_lane_needs_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (s_ras_n && &s_cas_n) |=> lane_act == '0);

endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder
   import dsd_pkg::*;
#(
   parameter int LANES        = 4,
   parameter int REFRESH_ROWS = 4096,
   parameter int ROW_W        = $clog2(REFRESH_ROWS),
   parameter int SELF_CYC     = 25000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ras_n,
   input  logic [LANES-1:0] cas_n,
   input  logic             we_n,
   input  logic             oe_n,
   input  logic [ROW_W-1:0] addr,
   output logic             cyc_valid,
   output logic [2:0]       cyc_type,
   output logic [ROW_W-1:0] cyc_row,
   output logic [ROW_W-1:0] refresh_row,
   output logic             self_refresh,
   output logic [LANES-1:0] dq_oe
);

   if (REFRESH_ROWS != 2048 && REFRESH_ROWS != 4096) begin : g_bad_rows
      $error("REFRESH_ROWS must be 2048 or 4096");
   end
   if (ROW_W != $clog2(REFRESH_ROWS)) begin : g_bad_width
      $error("ROW_W must match REFRESH_ROWS");
   end
   if (SELF_CYC < 2) begin : g_bad_self
      $error("SELF_CYC must be at least 2");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end

   logic             s_ras_n, ras_fall, ras_rise, s_we_n, we_fall, s_oe_n;
   logic [LANES-1:0] s_cas_n, cas_fall;
   logic [ROW_W-1:0] s_addr;
   logic             ref_inc, casfirst_go, in_access, in_casfirst;
   cyc_kind_e        kind_q;

   dsd_strobe_sampler #(.LANES(LANES), .ROW_W(ROW_W)) u_sampler (
      .clk      (clk),
      .rst_n    (rst_n),
      .ras_n    (ras_n),
      .cas_n    (cas_n),
      .we_n     (we_n),
      .oe_n     (oe_n),
      .addr     (addr),
      .s_ras_n  (s_ras_n),
      .ras_fall (ras_fall),
      .ras_rise (ras_rise),
      .s_cas_n  (s_cas_n),
      .cas_fall (cas_fall),
      .s_we_n   (s_we_n),
      .we_fall  (we_fall),
      .s_oe_n   (s_oe_n),
      .s_addr   (s_addr)
   );

   dsd_row_counter #(.ROW_W(ROW_W)) u_counter (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (ref_inc),
      .count (refresh_row)
   );

   dsd_cycle_fsm #(.LANES(LANES), .ROW_W(ROW_W), .SELF_CYC(SELF_CYC)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .ras_fall     (ras_fall),
      .ras_rise     (ras_rise),
      .s_cas_n      (s_cas_n),
      .cas_fall     (cas_fall),
      .s_we_n       (s_we_n),
      .we_fall      (we_fall),
      .s_addr       (s_addr),
      .ref_row      (refresh_row),
      .ref_inc      (ref_inc),
      .casfirst_go  (casfirst_go),
      .in_access    (in_access),
      .in_casfirst  (in_casfirst),
      .cyc_valid    (cyc_valid),
      .cyc_type     (kind_q),
      .cyc_row      (cyc_row),
      .self_refresh (self_refresh)
   );

   dsd_lane_drive #(.LANES(LANES)) u_lanes (
      .clk         (clk),
      .rst_n       (rst_n),
      .s_ras_n     (s_ras_n),
      .s_cas_n     (s_cas_n),
      .cas_fall    (cas_fall),
      .s_we_n      (s_we_n),
      .s_oe_n      (s_oe_n),
      .in_access   (in_access),
      .casfirst_go (casfirst_go),
      .dq_oe       (dq_oe)
   );

   assign cyc_type = kind_q;

   p_refresh_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_casfirst |-> dq_oe == '0);

   p_refresh_row_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_valid && cyc_type == 3'd5) |-> refresh_row == ROW_W'(cyc_row + 1'b1));

   p_access_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_access |=> $stable(refresh_row));

   p_drive_force_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_n || !we_n) |=> dq_oe == '0);

endmodule

// File: tb/dram_strobe_decoder_bench.sv
module dram_strobe_decoder_bench;

   localparam int LANES = 4;
   localparam int ROWS  = 2048;
   localparam int ROW_W = 11;
   localparam int SELF  = 40;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ras_n = 1'b1;
   logic [LANES-1:0] cas_n = '1;
   logic             we_n = 1'b1;
   logic             oe_n = 1'b0;
   logic [ROW_W-1:0] addr = '0;
   logic             cyc_valid;
   logic [2:0]       cyc_type;
   logic [ROW_W-1:0] cyc_row;
   logic [ROW_W-1:0] refresh_row;
   logic             self_refresh;
   logic [LANES-1:0] dq_oe;

   int n_vec = 0;
   int n_bad = 0;
   int exp_cnt = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dram_strobe_decoder #(.LANES(LANES), .REFRESH_ROWS(ROWS), .ROW_W(ROW_W),
                         .SELF_CYC(SELF)) u_dram_strobe_decoder (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .oe_n(oe_n), .addr(addr), .cyc_valid(cyc_valid), .cyc_type(cyc_type),
      .cyc_row(cyc_row), .refresh_row(refresh_row),
      .self_refresh(self_refresh), .dq_oe(dq_oe));

   task automatic chk(string what, int act, int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_cycle(string req, int et, int er);
      bit seen = 1'b0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (cyc_valid) begin
            seen = 1'b1;
            break;
         end
      end
      chk({req, " report strobe"}, int'(seen), 1);
      if (seen) begin
         chk({req, " kind"}, int'(cyc_type), et);
         chk({req, " row"}, int'(cyc_row), er);
         @(negedge clk);
         chk("R10 strobe single clock", int'(cyc_valid), 0);
      end
   endtask

   task automatic t_reset;
      chk("R12 reset dq_oe", int'(dq_oe), 0);
      chk("R12 reset strobe", int'(cyc_valid), 0);
      chk("R12 reset self flag", int'(self_refresh), 0);
      chk("R12 reset counter", int'(refresh_row), 0);
   endtask

   task automatic t_ras_only;
      addr = 11'h2A5; ras_n = 1'b0; tick(5);
      chk("R2 no drive", int'(dq_oe), 0);
      ras_n = 1'b1;
      expect_cycle("R2", 4, 'h2A5);
      chk("R2 counter unchanged", int'(refresh_row), exp_cnt);
   endtask

   task automatic t_casfirst_short;
      cas_n = '0; tick(2);
      ras_n = 1'b0; tick(6);
      chk("R1 no drive", int'(dq_oe), 0);
      chk("R9 short no self flag", int'(self_refresh), 0);
      ras_n = 1'b1;
      expect_cycle("R1", 5, exp_cnt);
      exp_cnt = (exp_cnt + 1) % ROWS;
      cas_n = '1; tick(2);
      chk("R1 counter advanced", int'(refresh_row), exp_cnt);
   endtask

   task automatic t_read;
      addr = 11'd5; ras_n = 1'b0; tick(3);
      cas_n = 4'b1010; tick(3);
      chk("R5 lane mask", int'(dq_oe), 'b0101);
      oe_n = 1'b1; tick(2);
      chk("R8 oe high off", int'(dq_oe), 0);
      oe_n = 1'b0; tick(2);
      chk("R8 oe low back on", int'(dq_oe), 'b0101);
      cas_n = '1; tick(3);
      chk("R7 hold after column rise", int'(dq_oe), 'b0101);
      ras_n = 1'b1;
      expect_cycle("R5", 1, 5);
      tick(2);
      chk("R7 off after both high", int'(dq_oe), 0);
   endtask

   task automatic t_early_write;
      addr = 11'd77; ras_n = 1'b0; tick(2);
      we_n = 1'b0; tick(2);
      cas_n = '0; tick(3);
      chk("R4 no drive", int'(dq_oe), 0);
      we_n = 1'b1; tick(3);
      chk("R4 no drive after we high", int'(dq_oe), 0);
      cas_n = '1; ras_n = 1'b1;
      expect_cycle("R4", 2, 77);
   endtask

   task automatic t_rmw;
      addr = 11'd300; ras_n = 1'b0; tick(3);
      cas_n = '0; tick(3);
      chk("R6 read part drives", int'(dq_oe), 'hF);
      we_n = 1'b0; tick(2);
      chk("R6 write part off", int'(dq_oe), 0);
      cas_n = '1; ras_n = 1'b1;
      expect_cycle("R6", 3, 300);
      we_n = 1'b1; tick(2);
      chk("R6 stays off", int'(dq_oe), 0);
   endtask

   task automatic t_hidden;
      addr = 11'd9; ras_n = 1'b0; tick(3);
      cas_n = '0; tick(3);
      ras_n = 1'b1;
      expect_cycle("R3 leading read", 1, 9);
      tick(3);
      ras_n = 1'b0; tick(4);
      chk("R3 drive kept", int'(dq_oe), 'hF);
      ras_n = 1'b1;
      expect_cycle("R3", 6, exp_cnt);
      exp_cnt = (exp_cnt + 1) % ROWS;
      chk("R3 counter advanced", int'(refresh_row), exp_cnt);
      cas_n = '1; tick(3);
      chk("R3 off after release", int'(dq_oe), 0);
   endtask

   task automatic t_self;
      cas_n = '0; tick(2);
      ras_n = 1'b0; tick(SELF + 30);
      chk("R9 self flag", int'(self_refresh), 1);
      ras_n = 1'b1;
      expect_cycle("R9", 7, exp_cnt);
      chk("R9 flag cleared", int'(self_refresh), 0);
      exp_cnt = (exp_cnt + 1) % ROWS;
      cas_n = '1; tick(2);
   endtask

   task automatic t_wrap;
      int n = ROWS - exp_cnt;
      for (int i = 0; i < n; i++) begin
         cas_n = '0; tick(1);
         ras_n = 1'b0; tick(2);
         ras_n = 1'b1; tick(2);
         cas_n = '1; tick(2);
      end
      exp_cnt = 0;
      chk("R11 wrapped to zero", int'(refresh_row), 0);
      cas_n = '0; tick(2);
      ras_n = 1'b0; tick(4);
      ras_n = 1'b1;
      expect_cycle("R11 after wrap", 5, 0);
      cas_n = '1; tick(2);
      chk("R11 counter one", int'(refresh_row), 1);
   endtask

   initial begin
      tick(4);
      rst_n = 1'b1;
      tick(2);
      t_reset();
      t_ras_only();
      t_casfirst_short();
      t_read();
      t_early_write();
      t_rmw();
      t_hidden();
      t_self();
      t_wrap();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule